// File: doc/BRIEF.md
# Peripheral Bus Bridge with Slot Decoder

This block sits on the main system bus as a single AHB-Lite slave that owns a 64 KB peripheral window. The system-level decoder asserts its select for any address from 0x4000_0000 to 0x4000_FFFF, so the bridge sees only the low 16 address bits. Each accepted main-bus transfer is turned into one non-pipelined APB transfer: a setup cycle followed by an access phase that waits on the peripheral's ready.

Inside the window, address bits [15:12] name one of four 4 KB peripheral slots, and bits [11:0] travel to the peripheral unchanged as its register offset. Slot 0 is the serial port, slot 1 the timer, slot 2 the general-purpose I/O and slot 3 the serial-peripheral controller. An address that lands in any higher slot reaches no peripheral and is answered with a bus error. The main bus is held in wait states for the full duration of each peripheral access, so a peripheral access always costs more cycles than a plain memory access. Both sides share one clock and one active-low reset.

The control is a five-state machine. IDLE waits for work. SETUP drives a peripheral select with enable low. ACCESS raises enable and stays until the peripheral is ready. ERR_WAIT and ERR_DONE form the two-cycle error reply. The transitions are: IDLE to SETUP (valid slot accepted), IDLE to ERR_WAIT (unused slot accepted), SETUP to ACCESS (always), ACCESS to ACCESS (peripheral not ready), ACCESS to IDLE (ready, nothing new), ACCESS to SETUP or ERR_WAIT (ready, with a new transfer accepted in the same cycle), ERR_WAIT to ERR_DONE (always), ERR_DONE to IDLE (nothing new), and ERR_DONE to SETUP or ERR_WAIT (new transfer accepted).

Top module: `periph_bus_bridge`

## Requirements
- R1: A transfer is accepted only in a cycle where the bridge is free and ahb_sel is 1, ahb_ready_in is 1 and ahb_trans is 2'b10 (NONSEQ) or 2'b11 (SEQ). Code 2'b00 (IDLE) and 2'b01 (BUSY), a low ahb_sel or a low ahb_ready_in start nothing: no peripheral select rises and the reply is a zero-wait OKAY (ahb_readyout 1, ahb_resp 0).
- R2: Window address bits [15:12] with value k in 0..3 drive apb_sel bit k (bit 0 serial port, bit 1 timer, bit 2 general-purpose I/O, bit 3 serial-peripheral controller); at most one apb_sel bit is ever high.
- R3: apb_addr carries the accepted window address bits [11:0] as the register offset, e.g. 16'h2004 gives offset 12'h004 on bit 2 and 16'h0008 gives 12'h008 on bit 0.
- R4: The cycle after a valid-slot acceptance is a setup cycle: the decoded apb_sel bit high and apb_enable low.
- R5: The setup cycle is always followed by an access phase with apb_enable high and the same apb_sel; the access phase repeats while apb_ready is low, with apb_sel, apb_addr, apb_write and apb_wdata unchanged.
- R6: For a write, the ahb_wdata value present in the first data-phase cycle appears on apb_wdata in the setup cycle and stays there through the access phase.
- R7: ahb_readyout is low from the setup cycle until the access cycle in which apb_ready is high; in that cycle ahb_readyout is high, and for a read ahb_rdata equals apb_rdata.
- R8: An accepted address with bits [15:12] above 3 raises no apb_sel bit and gets a two-cycle error: ahb_resp high with ahb_readyout low, then ahb_resp high with ahb_readyout high, then OKAY.
- R9: After the completing access cycle, apb_sel and apb_enable return low, unless a transfer was accepted in that same cycle, which then goes directly into its own setup cycle.
- R10: While rst_n is low, every apb_sel bit, apb_enable and ahb_resp are 0 and ahb_readyout is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both bus sides |
| rst_n | input | 1 | Active-low reset |
| ahb_sel | input | 1 | Window select from the system decoder |
| ahb_addr | input | 16 | Address within the peripheral window |
| ahb_trans | input | 2 | Transfer type (IDLE, BUSY, NONSEQ, SEQ) |
| ahb_write | input | 1 | 1 for write, 0 for read |
| ahb_wdata | input | 32 | Write data, valid in the data phase |
| ahb_ready_in | input | 1 | Bus-level ready, high when the previous transfer ends |
| ahb_readyout | output | 1 | Bridge ready; low inserts wait states |
| ahb_resp | output | 1 | 0 OKAY, 1 ERROR |
| ahb_rdata | output | 32 | Read data returned to the main bus |
| apb_addr | output | 12 | Register offset inside the selected peripheral |
| apb_sel | output | 4 | One select line per peripheral slot |
| apb_enable | output | 1 | High in the access phase |
| apb_write | output | 1 | Direction of the peripheral transfer |
| apb_wdata | output | 32 | Write data to the peripheral |
| apb_rdata | input | 32 | Read data from the selected peripheral |
| apb_ready | input | 1 | Peripheral ready, ends the access phase |

## Verification
Reads and writes are sent to each of the four slots with distinct offsets, which tells apart a wrong slot-to-select mapping, a swapped or truncated offset, and a lost direction bit. Access phases are stretched by zero, one and three peripheral wait cycles to separate correct holding of select, address and data from an early or late release of the main-bus wait. A transfer is chained into the completing cycle of the previous one, and compared with an isolated transfer, to show the direct return to setup rather than a detour through idle. Idle, busy, deselected and ready-low cycles, plus an address in an unused slot, show that nothing starts without a valid request and that the error reply has exactly two cycles with no select raised.

// File: rtl/pbridge_pkg.sv
package pbridge_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ACCESS,
        ST_ERR_WAIT,
        ST_ERR_DONE
    } br_state_t;

    localparam logic [1:0] HT_IDLE   = 2'b00;
    localparam logic [1:0] HT_BUSY   = 2'b01;
    localparam logic [1:0] HT_NONSEQ = 2'b10;
    localparam logic [1:0] HT_SEQ    = 2'b11;

endpackage

// File: rtl/slot_decoder.sv
module slot_decoder #(
    parameter int SLOT_W    = 4,
    parameter int NUM_SLOTS = 4
) (
    input  logic [SLOT_W-1:0]    slot_i,
    output logic [NUM_SLOTS-1:0] sel_o,
    output logic                 hit_o
);

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        assign sel_o[g] = (slot_i == SLOT_W'(g));
    end

    assign hit_o = |sel_o;

    // R2: a decode never names two slots at once
    always_comb begin
        p_decode_onehot_r2: assert ($onehot0(sel_o));
    end

endmodule

// File: rtl/bridge_fsm.sv
module bridge_fsm
    import pbridge_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hsel,
    input  logic       hready,
    input  logic [1:0] htrans,
    input  logic       slot_hit,
    input  logic       pready,
    output logic       accept_o,
    output logic       in_setup_o,
    output logic       in_access_o,
    output logic       psel_en_o,
    output logic       penable_o,
    output logic       hreadyout_o,
    output logic       hresp_o
);

    br_state_t state_q;
    br_state_t state_d;
    br_state_t launch;
    logic      can_take;
    logic      valid_req;

    assign valid_req = hsel && hready && ((htrans == HT_NONSEQ) || (htrans == HT_SEQ));
    assign can_take  = (state_q == ST_IDLE) || (state_q == ST_ERR_DONE) ||
                       ((state_q == ST_ACCESS) && pready);
    assign accept_o  = can_take && valid_req;
    assign launch    = slot_hit ? ST_SETUP : ST_ERR_WAIT;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     state_d = accept_o ? launch : ST_IDLE;
            ST_SETUP:    state_d = ST_ACCESS;
            ST_ACCESS: begin
                if (!pready)        state_d = ST_ACCESS;
                else if (accept_o)  state_d = launch;
                else                state_d = ST_IDLE;
            end
            ST_ERR_WAIT: state_d = ST_ERR_DONE;
            ST_ERR_DONE: state_d = accept_o ? launch : ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        in_setup_o  = 1'b0;
        in_access_o = 1'b0;
        psel_en_o   = 1'b0;
        penable_o   = 1'b0;
        hreadyout_o = 1'b1;
        hresp_o     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_SETUP: begin
                in_setup_o  = 1'b1;
                psel_en_o   = 1'b1;
                hreadyout_o = 1'b0;
            end
            ST_ACCESS: begin
                in_access_o = 1'b1;
                psel_en_o   = 1'b1;
                penable_o   = 1'b1;
                hreadyout_o = pready;
            end
            ST_ERR_WAIT: begin
                hreadyout_o = 1'b0;
                hresp_o     = 1'b1;
            end
            ST_ERR_DONE: begin
                hresp_o     = 1'b1;
            end
            default: begin
            end
        endcase
    end

    // R8: first error cycle is always followed by the releasing one
    p_err_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hresp_o && !hreadyout_o) |=> (hresp_o && hreadyout_o));

    // R8: the releasing error cycle never repeats itself
    p_err_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hresp_o && hreadyout_o) |=> !(hresp_o && hreadyout_o));

endmodule

// File: rtl/request_capture.sv
module request_capture #(
    parameter int OFF_W     = 12,
    parameter int DATA_W    = 32,
    parameter int NUM_SLOTS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 accept,
    input  logic                 in_setup,
    input  logic [OFF_W-1:0]     offset_i,
    input  logic                 write_i,
    input  logic [NUM_SLOTS-1:0] sel_i,
    input  logic [DATA_W-1:0]    wdata_i,
    output logic [OFF_W-1:0]     offset_o,
    output logic                 write_o,
    output logic [NUM_SLOTS-1:0] sel_o,
    output logic [DATA_W-1:0]    wdata_o
);

    logic [DATA_W-1:0] wdata_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            offset_o <= '0;
            write_o  <= 1'b0;
            sel_o    <= '0;
        end else if (accept) begin
            offset_o <= offset_i;
            write_o  <= write_i;
            sel_o    <= sel_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    wdata_q <= '0;
        else if (in_setup && write_o)  wdata_q <= wdata_i;
    end

    // Setup cycle forwards the data phase value; access phase replays the held copy.
    assign wdata_o = in_setup ? wdata_i : wdata_q;

endmodule

// File: rtl/periph_bus_bridge.sv
module periph_bus_bridge #(
    parameter int DATA_W    = 32,
    parameter int SLOT_LSB  = 12,
    parameter int SLOT_W    = 4,
    parameter int NUM_SLOTS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ahb_sel,
    input  logic [SLOT_LSB+SLOT_W-1:0] ahb_addr,
    input  logic [1:0]           ahb_trans,
    input  logic                 ahb_write,
    input  logic [DATA_W-1:0]    ahb_wdata,
    input  logic                 ahb_ready_in,
    output logic                 ahb_readyout,
    output logic                 ahb_resp,
    output logic [DATA_W-1:0]    ahb_rdata,
    output logic [SLOT_LSB-1:0]  apb_addr,
    output logic [NUM_SLOTS-1:0] apb_sel,
    output logic                 apb_enable,
    output logic                 apb_write,
    output logic [DATA_W-1:0]    apb_wdata,
    input  logic [DATA_W-1:0]    apb_rdata,
    input  logic                 apb_ready
);

    localparam int OFF_W = SLOT_LSB;
    localparam int WIN_W = SLOT_LSB + SLOT_W;

    logic [NUM_SLOTS-1:0] dec_sel;
    logic                 dec_hit;
    logic [NUM_SLOTS-1:0] sel_q;
    logic                 accept;
    logic                 in_setup;
    logic                 in_access;
    logic                 psel_en;

    slot_decoder #(
        .SLOT_W    (SLOT_W),
        .NUM_SLOTS (NUM_SLOTS)
    ) u_dec (
        .slot_i (ahb_addr[WIN_W-1:SLOT_LSB]),
        .sel_o  (dec_sel),
        .hit_o  (dec_hit)
    );

    bridge_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .hsel        (ahb_sel),
        .hready      (ahb_ready_in),
        .htrans      (ahb_trans),
        .slot_hit    (dec_hit),
        .pready      (apb_ready),
        .accept_o    (accept),
        .in_setup_o  (in_setup),
        .in_access_o (in_access),
        .psel_en_o   (psel_en),
        .penable_o   (apb_enable),
        .hreadyout_o (ahb_readyout),
        .hresp_o     (ahb_resp)
    );

    request_capture #(
        .OFF_W     (OFF_W),
        .DATA_W    (DATA_W),
        .NUM_SLOTS (NUM_SLOTS)
    ) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .in_setup (in_setup),
        .offset_i (ahb_addr[OFF_W-1:0]),
        .write_i  (ahb_write),
        .sel_i    (dec_sel),
        .wdata_i  (ahb_wdata),
        .offset_o (apb_addr),
        .write_o  (apb_write),
        .sel_o    (sel_q),
        .wdata_o  (apb_wdata)
    );

    assign apb_sel   = psel_en ? sel_q : '0;
    assign ahb_rdata = (in_access && !apb_write) ? apb_rdata : '0;

    // R2: never more than one peripheral selected
    p_single_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(apb_sel));

    // R1: a setup cycle is always preceded by a valid request
    p_start_needs_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (|apb_sel && !apb_enable) |-> $past(ahb_sel && ahb_ready_in && ahb_trans[1]));

    // R3: offset in setup equals the low bits of the accepted address
    p_offset_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|apb_sel && !apb_enable) |-> (apb_addr == $past(ahb_addr[OFF_W-1:0])));

    // R4, R5: setup is followed by access on the same line
    p_setup_to_access_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|apb_sel && !apb_enable) |=> (apb_enable && $stable(apb_sel)));

    // R5: access phase holds everything while the peripheral stalls
    p_access_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (apb_enable && !apb_ready) |=> (apb_enable && $stable(apb_sel) &&
            $stable(apb_addr) && $stable(apb_write) && $stable(apb_wdata)));

    // R5: enable only ever accompanies a select
    p_enable_with_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        apb_enable |-> (|apb_sel));

    // R7: main bus waits until the peripheral finishes
    p_wait_during_xfer_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|apb_sel && !(apb_enable && apb_ready)) |-> !ahb_readyout);

    // R8: an error reply never selects a peripheral
    p_no_sel_on_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ahb_resp |-> (apb_sel == '0));

    // R9: a completed access is never followed directly by another enable
    p_no_enable_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (apb_enable && apb_ready) |=> !apb_enable);

endmodule

// File: tb/periph_bus_bridge_bench.sv
module periph_bus_bridge_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ahb_sel = 1'b0;
    logic [15:0] ahb_addr = '0;
    logic [1:0]  ahb_trans = 2'b00;
    logic        ahb_write = 1'b0;
    logic [31:0] ahb_wdata = '0;
    logic        ahb_ready_in;
    logic        ahb_readyout;
    logic        ahb_resp;
    logic [31:0] ahb_rdata;
    logic [11:0] apb_addr;
    logic [3:0]  apb_sel;
    logic        apb_enable;
    logic        apb_write;
    logic [31:0] apb_wdata;
    logic [31:0] apb_rdata = '0;
    logic        apb_ready = 1'b0;
    logic        hold_ready_low = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    assign ahb_ready_in = hold_ready_low ? 1'b0 : ahb_readyout;

    periph_bus_bridge u_periph_bus_bridge (
        .clk          (clk),
        .rst_n        (rst_n),
        .ahb_sel      (ahb_sel),
        .ahb_addr     (ahb_addr),
        .ahb_trans    (ahb_trans),
        .ahb_write    (ahb_write),
        .ahb_wdata    (ahb_wdata),
        .ahb_ready_in (ahb_ready_in),
        .ahb_readyout (ahb_readyout),
        .ahb_resp     (ahb_resp),
        .ahb_rdata    (ahb_rdata),
        .apb_addr     (apb_addr),
        .apb_sel      (apb_sel),
        .apb_enable   (apb_enable),
        .apb_write    (apb_write),
        .apb_wdata    (apb_wdata),
        .apb_rdata    (apb_rdata),
        .apb_ready    (apb_ready)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_sel(input logic [15:0] a);
        return (a[15:12] < 4'd4) ? (4'b0001 << a[15:12]) : 4'b0000;
    endfunction

    task automatic bus_idle();
        ahb_sel   = 1'b0;
        ahb_trans = 2'b00;
    endtask

    task automatic addr_phase(input logic [15:0] a, input bit wr, input logic [1:0] tr);
        @(negedge clk);
        ahb_sel   = 1'b1;
        ahb_trans = tr;
        ahb_addr  = a;
        ahb_write = wr;
    endtask

    // Walks the data phase of an accepted transfer; optionally chains a new request
    task automatic data_phase(input logic [15:0] a, input bit wr, input logic [31:0] wd,
                              input logic [31:0] rd, input int waits,
                              input bit chain, input logic [15:0] na, input bit nwr);
        @(negedge clk);
        bus_idle();
        apb_ready = 1'b0;
        ahb_wdata = wd;
        apb_rdata = rd;
        #1;
        chk("R4 setup select", 32'(apb_sel), 32'(exp_sel(a)));
        chk("R4 setup enable low", 32'(apb_enable), 32'd0);
        chk("R3 offset", 32'(apb_addr), 32'(a[11:0]));
        chk("R5 direction", 32'(apb_write), 32'(wr));
        chk("R7 wait in setup", 32'(ahb_readyout), 32'd0);
        if (wr) chk("R6 setup write data", apb_wdata, wd);
        for (int i = 0; i <= waits; i++) begin
            @(negedge clk);
            apb_ready = (i == waits);
            ahb_wdata = 32'hDEAD_0000 | 32'(i);
            if (i == waits && chain) begin
                ahb_sel   = 1'b1;
                ahb_trans = 2'b10;
                ahb_addr  = na;
                ahb_write = nwr;
            end
            #1;
            chk("R5 access enable", 32'(apb_enable), 32'd1);
            chk("R5 access select held", 32'(apb_sel), 32'(exp_sel(a)));
            chk("R5 access offset held", 32'(apb_addr), 32'(a[11:0]));
            if (wr) chk("R6 access write data held", apb_wdata, wd);
            chk("R7 ready only when peripheral ready", 32'(ahb_readyout), 32'(i == waits));
            chk("R7 no error", 32'(ahb_resp), 32'd0);
            if (i == waits && !wr) chk("R7 read data returned", ahb_rdata, rd);
        end
        if (!chain) begin
            @(negedge clk);
            apb_ready = 1'b0;
            bus_idle();
            #1;
            chk("R9 select released", 32'(apb_sel), 32'd0);
            chk("R9 enable released", 32'(apb_enable), 32'd0);
            chk("R9 main bus free", 32'(ahb_readyout), 32'd1);
        end
    endtask

    task automatic t_reset();
        #1;
        chk("R10 reset select", 32'(apb_sel), 32'd0);
        chk("R10 reset enable", 32'(apb_enable), 32'd0);
        chk("R10 reset resp", 32'(ahb_resp), 32'd0);
        chk("R10 reset ready", 32'(ahb_readyout), 32'd1);
    endtask

    task automatic t_each_slot();
        addr_phase(16'h0008, 1'b0, 2'b10);
        data_phase(16'h0008, 1'b0, '0, 32'h1111_0008, 0, 1'b0, '0, 1'b0);
        addr_phase(16'h1FFC, 1'b1, 2'b10);
        data_phase(16'h1FFC, 1'b1, 32'hA5A5_1FFC, '0, 1, 1'b0, '0, 1'b0);
        addr_phase(16'h2004, 1'b1, 2'b11);
        data_phase(16'h2004, 1'b1, 32'h0000_2004, '0, 0, 1'b0, '0, 1'b0);
        addr_phase(16'h3ABC, 1'b0, 2'b11);
        data_phase(16'h3ABC, 1'b0, '0, 32'hC0DE_3ABC, 3, 1'b0, '0, 1'b0);
    endtask

    task automatic t_back_to_back();
        addr_phase(16'h2010, 1'b1, 2'b10);
        data_phase(16'h2010, 1'b1, 32'h1234_5678, '0, 2, 1'b1, 16'h1020, 1'b0);
        // R9: chained request enters setup directly
        data_phase(16'h1020, 1'b0, '0, 32'h8765_4321, 0, 1'b1, 16'h0ABC, 1'b1);
        data_phase(16'h0ABC, 1'b1, 32'h0F0F_F0F0, '0, 1, 1'b0, '0, 1'b0);
    endtask

    task automatic t_unused_slot();
        addr_phase(16'h5010, 1'b0, 2'b10);
        @(negedge clk);
        bus_idle();
        #1;
        chk("R8 first error resp", 32'(ahb_resp), 32'd1);
        chk("R8 first error wait", 32'(ahb_readyout), 32'd0);
        chk("R8 no select", 32'(apb_sel), 32'd0);
        @(negedge clk);
        #1;
        chk("R8 second error resp", 32'(ahb_resp), 32'd1);
        chk("R8 second error ready", 32'(ahb_readyout), 32'd1);
        chk("R8 no select", 32'(apb_sel), 32'd0);
        @(negedge clk);
        #1;
        chk("R8 back to okay", 32'(ahb_resp), 32'd0);
        chk("R8 ready after error", 32'(ahb_readyout), 32'd1);
        chk("R8 no enable", 32'(apb_enable), 32'd0);
    endtask

    task automatic idle_probe(input string what);
        @(negedge clk);
        bus_idle();
        hold_ready_low = 1'b0;
        #1;
        chk({what, " no select"}, 32'(apb_sel), 32'd0);
        chk({what, " zero-wait"}, 32'(ahb_readyout), 32'd1);
        chk({what, " okay"}, 32'(ahb_resp), 32'd0);
    endtask

    task automatic t_ignored_requests();
        addr_phase(16'h2000, 1'b1, 2'b00);
        idle_probe("R1 IDLE type");
        addr_phase(16'h2000, 1'b1, 2'b01);
        idle_probe("R1 BUSY type");
        @(negedge clk);
        ahb_sel = 1'b0; ahb_trans = 2'b10; ahb_addr = 16'h1000;
        idle_probe("R1 deselected");
        @(negedge clk);
        ahb_sel = 1'b1; ahb_trans = 2'b10; ahb_addr = 16'h3000; hold_ready_low = 1'b1;
        idle_probe("R1 ready low");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_each_slot();
        t_back_to_back();
        t_unused_slot();
        t_ignored_requests();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule